// File: doc/BRIEF.md
# Cascadable Two-Bit Arithmetic and Logic Slice

This block is a narrow datapath slice: each copy handles two bits of a machine word, and copies placed side by side form a processor of any even width. Every bus, register and result widens with the number of slices. Three two-bit inputs feed the slice. One carries memory data, one carries data from an input/output device, and one carries a mask or literal. Two two-bit outputs leave it. One is the memory address, held in an address register. The other is the accumulator. A seven-bit microfunction picks one storage location and one operation group. Operands, ALU result and carry-out settle within the cycle. Register writes happen on the next rising clock edge.

The slice holds eleven general registers, an accumulator and an address register. The mask input is ANDed bit by bit with the accumulator operand before that operand reaches the ALU. With the mask at all ones, an operation includes the accumulator. With it at all zeros, the accumulator drops out. This roughly doubles the set of useful functions: add becomes increment, subtract becomes decrement, and exclusive-NOR becomes complement. For arithmetic groups, group propagate and group generate outputs feed an external look-ahead carry unit, so wide words need not wait on a ripple carry.

Top module: `cascade_alu_slice`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after its release until the first write, the accumulator, the address register and all eleven general registers hold zero, so `addr_out` and `acc_out` read 0.
- R2: Register selection is `ufunc[3:0]` and the operation group is `ufunc[6:4]`. Group 0 (add to register) writes R + (ACC & mask) + carry_in into the selected register R. `carry_out` is the carry out of the top bit.
- R3: Group 1 (memory) writes mem_in + (ACC & mask) + carry_in into the accumulator. In the same edge, the address register loads the value the selected register held before that edge.
- R4: Group 2 (input) writes io_in + (ACC & mask) + carry_in into the accumulator. The address register is left alone.
- R5: Group 3 (subtract from register) writes R + ~(ACC & mask) + carry_in into R. `carry_out` is the carry out of that sum.
- R6: Groups 4, 5 and 6 write R & (ACC & mask), R | (ACC & mask) and ~(R ^ (ACC & mask)) into R. For these groups `carry_out` is carry_in OR (result nonzero), so a ripple across slices detects a nonzero word.
- R7: Group 7 shifts R right by one. carry_in enters the top bit, and the bit shifted out of bit 0 appears on `carry_out`.
- R8: For groups 0 to 3, with A the first operand and B the second (the masked accumulator, or its complement in group 3), `grp_prop` = AND over bits of (A|B) and `grp_gen` = A1&B1 | (A1|B1)&A0&B0. `carry_out` equals grp_gen | grp_prop & carry_in. For groups 4 to 7 both look-ahead outputs are 0.
- R9: Select codes 0 to 10 address the general registers and code 11 addresses the accumulator. Codes 12 to 15 read as zero and write nothing.
- R10: A mask of 00 removes the accumulator from the operand, and a mask of 11 passes it whole. Group 0 with mask 00 and carry_in 1 increments R. Group 3 with mask 00 and carry_in 0 decrements R.
- R11: `addr_out` always shows the address register and `acc_out` always shows the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ufunc | input | 7 | Microfunction: [6:4] operation group, [3:0] register select |
| mem_in | input | 2 | Memory data input bus |
| io_in | input | 2 | Input/output device data bus |
| mask_in | input | 2 | Mask or literal, ANDed with the accumulator operand |
| carry_in | input | 1 | Carry in, shift-in bit, or nonzero-chain input |
| carry_out | output | 1 | Carry out, shifted-out bit, or nonzero-chain output |
| grp_prop | output | 1 | Group propagate for look-ahead |
| grp_gen | output | 1 | Group generate for look-ahead |
| addr_out | output | 2 | Memory address register contents |
| acc_out | output | 2 | Accumulator contents |

## Verification
The assertions check the combinational parts on every cycle. They cover the agreement of carry-out with the look-ahead pair in arithmetic groups, the silent look-ahead outputs in logic groups, the shifted-out bit, and the zero read of unused select codes. Across one edge they also check the zero state after reset, the address register capture in the memory group, and the unmasked load of the input bus. What the general registers hold can only be seen through the directed scenarios, which copy each register into the address register and compare the contents against a bench model. Those scenarios cover increment versus add under the mask, decrement versus subtract, the nonzero chain, shifts, writes refused for unused codes, and a long pseudo-random run across all groups.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;
    localparam int SEL_W = 4;
    localparam int GRP_W = 3;

    typedef enum logic [GRP_W-1:0] {
        GRP_ADD_R = 3'd0,
        GRP_MEM   = 3'd1,
        GRP_INP   = 3'd2,
        GRP_SUB_R = 3'd3,
        GRP_AND   = 3'd4,
        GRP_OR    = 3'd5,
        GRP_XNOR  = 3'd6,
        GRP_SHR   = 3'd7
    } grp_e;
endpackage

// File: rtl/bitslice_regs.sv
module bitslice_regs #(
    parameter int W     = 2,
    parameter int NREG  = 11,
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic             r_we,
    input  logic [W-1:0]     r_data,
    input  logic             ac_we,
    input  logic [W-1:0]     ac_data,
    input  logic             mar_we,
    output logic [W-1:0]     rd_val,
    output logic [W-1:0]     ac_q,
    output logic [W-1:0]     mar_q
);
    localparam logic [SEL_W-1:0] ACC_SEL = SEL_W'(NREG);

    logic [NREG-1:0][W-1:0] gpr_q;

    generate
        for (genvar gi = 0; gi < NREG; gi++) begin : g_gpr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    gpr_q[gi] <= '0;
                else if (r_we && rd_sel == SEL_W'(gi))
                    gpr_q[gi] <= r_data;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ac_q <= '0;
        else if (ac_we)
            ac_q <= ac_data;
        else if (r_we && rd_sel == ACC_SEL)
            ac_q <= r_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mar_q <= '0;
        else if (mar_we)
            mar_q <= rd_val;
    end

    always_comb begin
        rd_val = '0;
        for (int ri = 0; ri < NREG; ri++)
            if (rd_sel == SEL_W'(ri))
                rd_val = gpr_q[ri];
        if (rd_sel == ACC_SEL)
            rd_val = ac_q;
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_slice_pkg::*;
#(
    parameter int W = 2
) (
    input  grp_e         grp,
    input  logic [W-1:0] r_val,
    input  logic [W-1:0] ac_val,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] mem_d,
    input  logic [W-1:0] io_d,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         gp,
    output logic         gg,
    output logic         r_we,
    output logic         ac_we,
    output logic         mar_we
);
    logic [W-1:0] b_masked;
    logic [W-1:0] a_op;
    logic [W-1:0] b_op;
    logic [W:0]   sum;
    logic         arith;
    logic         logic_grp;

    assign b_masked = ac_val & mask;

    // operation decode and result
    always_comb begin
        a_op      = '0;
        b_op      = '0;
        arith     = 1'b0;
        logic_grp = 1'b0;
        res       = '0;
        cout      = 1'b0;
        r_we      = 1'b0;
        ac_we     = 1'b0;
        mar_we    = 1'b0;
        sum       = '0;
        unique case (grp)
            GRP_ADD_R: begin a_op = r_val; b_op = b_masked;  arith = 1'b1; r_we = 1'b1; end
            GRP_MEM:   begin a_op = mem_d; b_op = b_masked;  arith = 1'b1; ac_we = 1'b1; mar_we = 1'b1; end
            GRP_INP:   begin a_op = io_d;  b_op = b_masked;  arith = 1'b1; ac_we = 1'b1; end
            GRP_SUB_R: begin a_op = r_val; b_op = ~b_masked; arith = 1'b1; r_we = 1'b1; end
            GRP_AND:   begin res = r_val & b_masked;    logic_grp = 1'b1; r_we = 1'b1; end
            GRP_OR:    begin res = r_val | b_masked;    logic_grp = 1'b1; r_we = 1'b1; end
            GRP_XNOR:  begin res = ~(r_val ^ b_masked); logic_grp = 1'b1; r_we = 1'b1; end
            GRP_SHR:   begin res = {cin, r_val[W-1:1]}; cout = r_val[0]; r_we = 1'b1; end
        endcase
        if (arith) begin
            sum  = {1'b0, a_op} + {1'b0, b_op} + {{W{1'b0}}, cin};
            res  = sum[W-1:0];
            cout = sum[W];
        end
        if (logic_grp)
            cout = cin | (|res);
    end

    // look-ahead group terms, formed from operand bits only
    always_comb begin
        gp = arith;
        gg = 1'b0;
        for (int bi = 0; bi < W; bi++) begin
            gg = (a_op[bi] & b_op[bi]) | ((a_op[bi] | b_op[bi]) & gg);
            gp = gp & (a_op[bi] | b_op[bi]);
        end
        if (!arith)
            gg = 1'b0;
    end
endmodule

// File: rtl/cascade_alu_slice.sv
module cascade_alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W    = 2,
    parameter int NREG = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [GRP_W+SEL_W-1:0]   ufunc,
    input  logic [W-1:0]             mem_in,
    input  logic [W-1:0]             io_in,
    input  logic [W-1:0]             mask_in,
    input  logic                     carry_in,
    output logic                     carry_out,
    output logic                     grp_prop,
    output logic                     grp_gen,
    output logic [W-1:0]             addr_out,
    output logic [W-1:0]             acc_out
);
    grp_e             grp;
    logic [SEL_W-1:0] sel;
    logic [W-1:0]     rd_val;
    logic [W-1:0]     ac_q;
    logic [W-1:0]     mar_q;
    logic [W-1:0]     res;
    logic             r_we;
    logic             ac_we;
    logic             mar_we;

    assign grp = grp_e'(ufunc[GRP_W+SEL_W-1:SEL_W]);
    assign sel = ufunc[SEL_W-1:0];

    bitslice_regs #(.W(W), .NREG(NREG), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd_sel(sel),
        .r_we(r_we), .r_data(res),
        .ac_we(ac_we), .ac_data(res), .mar_we(mar_we),
        .rd_val(rd_val), .ac_q(ac_q), .mar_q(mar_q)
    );

    bitslice_alu #(.W(W)) u_alu (
        .grp(grp), .r_val(rd_val), .ac_val(ac_q), .mask(mask_in),
        .mem_d(mem_in), .io_d(io_in), .cin(carry_in),
        .res(res), .cout(carry_out), .gp(grp_prop), .gg(grp_gen),
        .r_we(r_we), .ac_we(ac_we), .mar_we(mar_we)
    );

    assign addr_out = mar_q;
    assign acc_out  = ac_q;
endmodule

// File: rtl/cascade_alu_slice_chk.sv
module cascade_alu_slice_chk #(
    parameter int W = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [6:0]   ufunc,
    input logic [W-1:0] io_in,
    input logic [W-1:0] mask_in,
    input logic         carry_in,
    input logic         carry_out,
    input logic         grp_prop,
    input logic         grp_gen,
    input logic [W-1:0] addr_out,
    input logic [W-1:0] acc_out,
    input logic [W-1:0] rd_val
);
    logic [2:0] grp;
    assign grp = ufunc[6:4];

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (acc_out == '0 && addr_out == '0));

    // R8
    lookahead_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp <= 3'd3) |-> (carry_out == (grp_gen | (grp_prop & carry_in))));

    // R8
    lookahead_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp >= 3'd4) |-> (!grp_prop && !grp_gen));

    // R7
    shift_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == 3'd7) |-> (carry_out == rd_val[0]));

    // R9
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ufunc[3:0] >= 4'd12) |-> (rd_val == '0));

    // R3
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == 3'd1) |=> (addr_out == $past(rd_val)));

    // R4
    input_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == 3'd2 && mask_in == '0) |=>
        (acc_out == $past(io_in + {{(W-1){1'b0}}, carry_in})));
endmodule

bind cascade_alu_slice cascade_alu_slice_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ufunc(ufunc), .io_in(io_in),
    .mask_in(mask_in), .carry_in(carry_in), .carry_out(carry_out),
    .grp_prop(grp_prop), .grp_gen(grp_gen), .addr_out(addr_out),
    .acc_out(acc_out), .rd_val(rd_val)
);

// File: tb/test_cascade_alu_slice.sv
`timescale 1ns/1ps
module test_cascade_alu_slice;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] ufunc = '0;
    logic [1:0] mem_in = '0, io_in = '0, mask_in = '0;
    logic       carry_in = 1'b0;
    logic       carry_out, grp_prop, grp_gen;
    logic [1:0] addr_out, acc_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [1:0] mg [0:10];
    logic [1:0] mac, mmar;

    cascade_alu_slice i_cascade_alu_slice (
        .clk(clk), .rst_n(rst_n), .ufunc(ufunc), .mem_in(mem_in),
        .io_in(io_in), .mask_in(mask_in), .carry_in(carry_in),
        .carry_out(carry_out), .grp_prop(grp_prop), .grp_gen(grp_gen),
        .addr_out(addr_out), .acc_out(acc_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one microinstruction after a falling edge, check combinational
    // outputs, then the registered outputs after the rising edge.
    task automatic run_op(input logic [2:0] g, input logic [3:0] s, input logic [1:0] k,
                          input logic [1:0] m, input logic [1:0] io, input logic c,
                          input string req);
        logic [1:0] rv, bm, a, b, r;
        logic [2:0] t;
        logic e_co, e_x, e_y, w_r, w_ac, w_mar;
        ufunc = {g, s}; mask_in = k; mem_in = m; io_in = io; carry_in = c;
        rv = (s < 4'd11) ? mg[s] : ((s == 4'd11) ? mac : 2'b00);
        bm = mac & k;
        a = 2'b00; b = 2'b00; r = 2'b00; e_co = 1'b0; e_x = 1'b0; e_y = 1'b0;
        w_r = 1'b0; w_ac = 1'b0; w_mar = 1'b0;
        case (g)
            3'd0: begin a = rv; b = bm;  w_r = 1'b1; end
            3'd1: begin a = m;  b = bm;  w_ac = 1'b1; w_mar = 1'b1; end
            3'd2: begin a = io; b = bm;  w_ac = 1'b1; end
            3'd3: begin a = rv; b = ~bm; w_r = 1'b1; end
            3'd4: begin r = rv & bm;     w_r = 1'b1; e_co = c | (r != 0); end
            3'd5: begin r = rv | bm;     w_r = 1'b1; e_co = c | (r != 0); end
            3'd6: begin r = ~(rv ^ bm);  w_r = 1'b1; e_co = c | (r != 0); end
            default: begin r = {c, rv[1]}; e_co = rv[0]; w_r = 1'b1; end
        endcase
        if (g <= 3'd3) begin
            t = {1'b0, a} + {1'b0, b} + {2'b00, c};
            r = t[1:0]; e_co = t[2];
            e_x = (a[0] | b[0]) & (a[1] | b[1]);
            e_y = (a[1] & b[1]) | ((a[1] | b[1]) & a[0] & b[0]);
        end
        #1;
        chk(req, "carry_out", carry_out, e_co);
        chk("R8", "grp_prop", grp_prop, e_x);
        chk("R8", "grp_gen", grp_gen, e_y);
        @(posedge clk);
        if (w_mar) mmar = rv;
        if (w_ac) mac = r;
        if (w_r) begin
            if (s < 4'd11) mg[s] = r;
            else if (s == 4'd11) mac = r;
        end
        #1;
        chk(req, "acc_out", acc_out, mac);
        chk("R11", "addr_out", addr_out, mmar);
        @(negedge clk);
    endtask

    task automatic readback(input logic [3:0] s, input string req);
        run_op(3'd1, s, 2'b00, 2'b00, 2'b00, 1'b0, req);
    endtask

    task automatic t_reset;
        #1;
        chk("R1", "acc_out in reset", acc_out, 0);
        chk("R1", "addr_out in reset", addr_out, 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        for (int ri = 0; ri < 11; ri++) readback(4'(ri), "R1");
    endtask

    task automatic t_load_add;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b10, 1'b0, "R4");  // AC = 2
        run_op(3'd0, 4'd3, 2'b11, 2'b00, 2'b00, 1'b0, "R2");  // R3 = 2
        run_op(3'd0, 4'd3, 2'b11, 2'b00, 2'b00, 1'b1, "R2");  // R3 = 2+2+1 = 1, carry
        readback(4'd3, "R3");
        chk("R3", "captured R3", addr_out, 1);
        run_op(3'd1, 4'd11, 2'b11, 2'b01, 2'b00, 1'b0, "R3"); // AC = 1 + 0
    endtask

    task automatic t_mask;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b11, 1'b0, "R4");  // AC = 3
        run_op(3'd0, 4'd4, 2'b00, 2'b00, 2'b00, 1'b1, "R10"); // increment R4
        run_op(3'd0, 4'd4, 2'b00, 2'b00, 2'b00, 1'b1, "R10");
        run_op(3'd3, 4'd4, 2'b00, 2'b00, 2'b00, 1'b0, "R10"); // decrement
        run_op(3'd0, 4'd4, 2'b11, 2'b00, 2'b00, 1'b0, "R10"); // add AC
        run_op(3'd0, 4'd4, 2'b01, 2'b00, 2'b00, 1'b0, "R10"); // partial mask
        readback(4'd4, "R10");
    endtask

    task automatic t_sub;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b01, 1'b0, "R4");  // AC = 1
        run_op(3'd3, 4'd5, 2'b11, 2'b00, 2'b00, 1'b1, "R5");  // 0 - 1 = 3, no carry
        run_op(3'd3, 4'd5, 2'b11, 2'b00, 2'b00, 1'b1, "R5");  // 3 - 1 = 2, carry
        run_op(3'd3, 4'd5, 2'b00, 2'b00, 2'b00, 1'b0, "R5");  // decrement to 1
        readback(4'd5, "R5");
    endtask

    task automatic t_logic;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b10, 1'b0, "R4");  // AC = 2
        run_op(3'd5, 4'd6, 2'b11, 2'b00, 2'b00, 1'b0, "R6");  // OR -> 2, nonzero
        run_op(3'd4, 4'd6, 2'b01, 2'b00, 2'b00, 1'b0, "R6");  // AND masked -> 0
        run_op(3'd4, 4'd6, 2'b01, 2'b00, 2'b00, 1'b1, "R6");  // zero but chain in
        run_op(3'd6, 4'd6, 2'b00, 2'b00, 2'b00, 1'b0, "R6");  // NOT -> 3
        run_op(3'd6, 4'd6, 2'b11, 2'b00, 2'b00, 1'b0, "R6");  // XNOR with 2 -> 2
        readback(4'd6, "R6");
    endtask

    task automatic t_shift;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b11, 1'b0, "R4");
        run_op(3'd0, 4'd7, 2'b11, 2'b00, 2'b00, 1'b0, "R7");  // R7 = 3
        run_op(3'd7, 4'd7, 2'b00, 2'b00, 2'b00, 1'b0, "R7");  // -> 1, out 1
        run_op(3'd7, 4'd7, 2'b00, 2'b00, 2'b00, 1'b1, "R7");  // -> 2, out 1
        run_op(3'd7, 4'd7, 2'b00, 2'b00, 2'b00, 1'b0, "R7");  // -> 1, out 0
        readback(4'd7, "R7");
    endtask

    task automatic t_unused_sel;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b11, 1'b0, "R9");
        for (int si = 12; si < 16; si++) begin
            run_op(3'd0, 4'(si), 2'b11, 2'b00, 2'b00, 1'b1, "R9");
            readback(4'(si), "R9");
            chk("R9", "unused select reads zero", addr_out, 0);
        end
        for (int ri = 0; ri < 11; ri++) readback(4'(ri), "R9");
    endtask

    task automatic t_lookahead;
        run_op(3'd2, 4'd0, 2'b00, 2'b00, 2'b01, 1'b0, "R8");  // AC = 1
        run_op(3'd2, 4'd0, 2'b11, 2'b00, 2'b11, 1'b0, "R8");  // 3+1: prop 1, gen 1
        run_op(3'd2, 4'd0, 2'b11, 2'b00, 2'b11, 1'b1, "R8");  // AC=0: prop 1 gen 0
    endtask

    task automatic t_sweep;
        logic [15:0] lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_op(lf[2:0], lf[6:3], lf[8:7], lf[10:9], lf[12:11], lf[13], "R2");
        end
        for (int ri = 0; ri < 12; ri++) readback(4'(ri), "R11");
    endtask

    initial begin
        for (int ri = 0; ri < 11; ri++) mg[ri] = 2'b00;
        mac = 2'b00; mmar = 2'b00;
        t_reset();
        t_load_add();
        t_mask();
        t_sub();
        t_logic();
        t_shift();
        t_unused_sel();
        t_lookahead();
        t_sweep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule